// File: doc/BRIEF.md
# Sectored Direct-Mapped Cache Tag Directory

This block keeps the tag directory of a 32 KB direct-mapped, write-through cache that serves a 32-bit byte-addressed processor. It does not hold data. The directory has one entry for each of 1024 sets. An entry carries one tag and one tag-valid flag, plus a separate valid flag for each of the eight 32-bit words (lines) in the set. For every processor access, the block reports in the same cycle whether the access hits. It also gives the word position in the data array, and for a read that misses it raises a fetch request.

The block tracks a single outstanding read miss. The directory is not changed when the miss is found. It is changed when the memory side signals that the line fill is complete. A fill either marks one more word valid under the current tag, or takes the set over for a new tag and drops every other word. Two inputs keep the directory coherent: a snoop port that removes single words written by other bus masters, and a flush strobe that empties the whole directory in one cycle.

Top module: `cache_dir_sectored`

## Requirements
- R1: An address splits as follows. Bits 31:15 are the tag, bits 14:5 are the set, and bits 4:2 select the word within the set. `line_index` always equals `acc_addr[14:2]`, i.e. {set, word}.
- R2: `hit` is combinational in the access cycle. It is 1 only when all of these hold: `acc_valid` is set, no fill is pending, the set's tag-valid flag is set, the stored tag equals address bits 31:15, and the selected word's valid flag is set. This applies to both reads and writes.
- R3: A read that does not hit raises `fetch_req` in the same cycle and makes a fill pending. While a fill is pending, accesses produce neither `hit` nor `fetch_req`, and they do not change the directory.
- R4: A fill completes on the first `fill_done` after the miss. If the set then holds the missed tag with tag-valid set, only the missed word's flag is set. The other seven word flags keep their values.
- R5: If the tag differs or tag-valid is clear when the fill completes, the set takes the missed tag and tag-valid is set. The missed word becomes valid and the other seven word flags are cleared.
- R6: Writes never raise `fetch_req` and never change the directory, whether they hit or miss.
- R7: A snoop whose tag matches a valid set clears only the snooped word's flag. A snoop with a different tag, or to a set whose tag is not valid, has no effect.
- R8: A flush clears the tag-valid flag of all 1024 sets in one cycle.
- R9: Within one cycle, flush and snoop are applied first. The access is then judged against the updated entry, and a completing fill is applied last.
- R10: After reset every tag-valid flag is clear and no fill is pending.
- R11: `fill_done` while no fill is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Processor access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Processor byte address |
| snp_valid | input | 1 | Snoop invalidate strobe |
| snp_addr | input | 32 | Address written by another bus master |
| flush | input | 1 | Empty the whole directory |
| fill_done | input | 1 | Memory has delivered the pending line |
| hit | output | 1 | Access hits in the directory |
| fetch_req | output | 1 | Read miss, fetch the word from memory |
| line_index | output | 13 | Word position in the data array, {set, word} |

## Verification
The hardest cases to reach are the ones where events meet inside a single set in a single cycle. Examples are a snoop striking the very word being read, a flush arriving together with a fill that completes, and a fill that lands after a snoop or flush has changed the entry since the miss. Purely random addresses almost never revisit a set. The stimulus therefore draws tags from three values and sets from four (including 0 and 1023), and it often copies the access address into the snoop port. A reference directory in the bench, written from the requirements, predicts every cycle. Directed sequences come first and walk through the word-miss, tag-replacement, snoop-priority, write-miss, and stray-fill cases one at a time.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
    localparam int ADDR_W   = 32;
    localparam int WORD_LSB = 2;
    localparam int LINE_W   = 3;
    localparam int SET_W    = 10;
    localparam int TAG_W    = ADDR_W - SET_W - LINE_W - WORD_LSB;
    localparam int SETS     = 1 << SET_W;
    localparam int LINES    = 1 << LINE_W;
    localparam int IDX_W    = SET_W + LINE_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set;
        logic [LINE_W-1:0] line;
    } addr_f_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             tv;
        logic [LINES-1:0] lv;
    } dir_ent_t;

    typedef struct packed {
        logic              valid;
        logic [SET_W-1:0]  set;
        logic [LINE_W-1:0] line;
    } clr_t;

    typedef struct packed {
        logic              valid;
        logic              replace;
        logic [SET_W-1:0]  set;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] line;
    } fill_t;

    function automatic addr_f_t split_addr(input logic [ADDR_W-1:0] a);
        addr_f_t f;
        f.tag  = a[ADDR_W-1 -: TAG_W];
        f.set  = a[WORD_LSB+LINE_W +: SET_W];
        f.line = a[WORD_LSB +: LINE_W];
        return f;
    endfunction
endpackage

// File: rtl/cdir_match.sv
module cdir_match
    import cdir_pkg::*;
(
    input  dir_ent_t          ent,
    input  logic [TAG_W-1:0]  tag,
    input  logic [LINE_W-1:0] line,
    output logic              tag_ok,
    output logic              line_ok
);
    always_comb begin
        tag_ok  = ent.tv && (ent.tag == tag);
        line_ok = tag_ok && ent.lv[line];
    end
endmodule

// File: rtl/cdir_store.sv
module cdir_store
    import cdir_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  clr_t                       clr,
    input  fill_t                      fill,
    input  logic [NRD-1:0][SET_W-1:0]  rd_set,
    output dir_ent_t [NRD-1:0]         rd_ent
);
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  tv_q;
    logic [LINES-1:0] lv_q  [SETS];

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_ent[g].tag = tag_q[rd_set[g]];
        assign rd_ent[g].tv  = tv_q[rd_set[g]];
        assign rd_ent[g].lv  = lv_q[rd_set[g]];
    end

    // Order of nonblocking writes gives the priority flush, snoop, fill.
    always_ff @(posedge clk) begin
        if (rst) begin
            tv_q <= '0;
            for (int i = 0; i < SETS; i++) lv_q[i] <= '0;
        end else begin
            if (flush) tv_q <= '0;
            if (clr.valid) lv_q[clr.set][clr.line] <= 1'b0;
            if (fill.valid) begin
                if (fill.replace) begin
                    tag_q[fill.set] <= fill.tag;
                    tv_q[fill.set]  <= 1'b1;
                    lv_q[fill.set]  <= LINES'(1) << fill.line;
                end else begin
                    lv_q[fill.set][fill.line] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cdir_pending.sv
module cdir_pending
    import cdir_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  addr_f_t start_f,
    input  logic    fill_done,
    output logic    busy,
    output addr_f_t held,
    output logic    fire
);
    assign fire = fill_done && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            held <= '0;
        end else if (fire) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            held <= start_f;
        end
    end
endmodule

// File: rtl/cache_dir_sectored.sv
module cache_dir_sectored
    import cdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              flush,
    input  logic              fill_done,
    output logic              hit,
    output logic              fetch_req,
    output logic [IDX_W-1:0]  line_index
);
    localparam int RD_ACC = 0;
    localparam int RD_SNP = 1;
    localparam int RD_PND = 2;
    localparam int NRD    = 3;

    addr_f_t af, sf, held;
    logic    busy, fire;
    logic [NRD-1:0][SET_W-1:0] rd_set;
    dir_ent_t [NRD-1:0]        rd_ent;
    dir_ent_t                  acc_view;
    clr_t                      clr;
    fill_t                     fill;
    logic s_tag_ok, s_line_ok, a_tag_ok, a_line_ok, p_tag_ok, p_line_ok;
    logic snp_kill, acc_live;

    assign af = split_addr(acc_addr);
    assign sf = split_addr(snp_addr);

    assign rd_set[RD_ACC] = af.set;
    assign rd_set[RD_SNP] = sf.set;
    assign rd_set[RD_PND] = held.set;

    cdir_store #(.NRD(NRD)) u_store (
        .clk(clk), .rst(rst), .flush(flush), .clr(clr), .fill(fill),
        .rd_set(rd_set), .rd_ent(rd_ent)
    );

    // Snoop: only a matching, valid tag loses a word; flush goes first.
    cdir_match u_snp (
        .ent(rd_ent[RD_SNP]), .tag(sf.tag), .line(sf.line),
        .tag_ok(s_tag_ok), .line_ok(s_line_ok)
    );
    assign snp_kill = snp_valid && !flush && s_tag_ok;
    assign clr      = '{valid: snp_kill, set: sf.set, line: sf.line};

    // Access sees the entry after this cycle's flush and snoop.
    always_comb begin
        acc_view = rd_ent[RD_ACC];
        if (flush) acc_view.tv = 1'b0;
        if (snp_kill && (sf.set == af.set)) acc_view.lv[sf.line] = 1'b0;
    end

    cdir_match u_acc (
        .ent(acc_view), .tag(af.tag), .line(af.line),
        .tag_ok(a_tag_ok), .line_ok(a_line_ok)
    );

    assign acc_live   = acc_valid && !busy;
    assign hit        = acc_live && a_line_ok;
    assign fetch_req  = acc_live && !acc_write && !a_line_ok;
    assign line_index = {af.set, af.line};

    cdir_pending u_pend (
        .clk(clk), .rst(rst), .start(fetch_req), .start_f(af),
        .fill_done(fill_done), .busy(busy), .held(held), .fire(fire)
    );

    // Fill decides word-only versus takeover on the entry as it stands now.
    cdir_match u_pnd (
        .ent(rd_ent[RD_PND]), .tag(held.tag), .line(held.line),
        .tag_ok(p_tag_ok), .line_ok(p_line_ok)
    );
    assign fill = '{valid: fire, replace: !(p_tag_ok && !flush),
                    set: held.set, tag: held.tag, line: held.line};
endmodule

// File: rtl/cache_dir_sectored_chk.sv
module cache_dir_sectored_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [31:0] acc_addr,
    input logic        snp_valid,
    input logic [31:0] snp_addr,
    input logic        flush,
    input logic        fill_done,
    input logic        hit,
    input logic        fetch_req
);
    assert_fetch_only_read_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (acc_valid && !acc_write));

    assert_write_no_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |-> !fetch_req);

    assert_hit_excl_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        !(hit && fetch_req));

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> (!fetch_req && !hit));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (flush && !fill_done) |=> !hit);

    assert_reset_empty_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !hit);

    assert_snoop_first_R9: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && acc_valid && (snp_addr[31:2] == acc_addr[31:2])) |-> !hit);
endmodule

bind cache_dir_sectored cache_dir_sectored_chk u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .flush(flush), .fill_done(fill_done), .hit(hit), .fetch_req(fetch_req)
);

// File: tb/sim_cache_dir_sectored.sv
module sim_cache_dir_sectored;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 0, acc_write = 0, snp_valid = 0, flush = 0, fill_done = 0;
    logic [31:0] acc_addr = '0, snp_addr = '0;
    logic        hit, fetch_req;
    logic [12:0] line_index;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Reference directory built from the requirements.
    logic [16:0] m_tag [1024];
    bit          m_tv  [1024];
    logic [7:0]  m_lv  [1024];
    bit          m_busy;
    logic [16:0] p_tag;
    logic [9:0]  p_set;
    logic [2:0]  p_line;

    cache_dir_sectored u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .flush(flush), .fill_done(fill_done), .hit(hit), .fetch_req(fetch_req),
        .line_index(line_index)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [16:0] t, input logic [9:0] s,
                                       input logic [2:0] l);
        return {t, s, l, 2'b00};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin m_tv[i] = 0; m_lv[i] = '0; m_tag[i] = '0; end
        m_busy = 0;
    endtask

    task automatic step(input bit av, input bit aw, input logic [31:0] aa,
                        input bit sv, input logic [31:0] sa,
                        input bit fl, input bit fd, input string req);
        logic [16:0] t, st;
        logic [9:0]  s, ss;
        logic [2:0]  l, sl;
        logic [7:0]  vlv;
        bit vtv, skill, ehit, efetch;
        @(negedge clk);
        acc_valid = av; acc_write = aw; acc_addr = aa;
        snp_valid = sv; snp_addr = sa; flush = fl; fill_done = fd;
        #1;
        t = aa[31:15]; s = aa[14:5]; l = aa[4:2];
        st = sa[31:15]; ss = sa[14:5]; sl = sa[4:2];
        skill = sv && !fl && m_tv[ss] && (m_tag[ss] == st);
        vtv = m_tv[s] && !fl;
        vlv = m_lv[s];
        if (skill && ss == s) vlv[sl] = 1'b0;
        ehit   = av && !m_busy && vtv && (m_tag[s] == t) && vlv[l];
        efetch = av && !m_busy && !aw && !ehit;
        chk(hit == ehit, req, "hit", 32'(hit), 32'(ehit));
        chk(fetch_req == efetch, req, "fetch_req", 32'(fetch_req), 32'(efetch));
        if (av) chk(line_index == {s, l}, "R1", "line_index", 32'(line_index), 32'({s, l}));
        // model update: flush, snoop, fill, then capture a new miss
        if (fl) for (int i = 0; i < 1024; i++) m_tv[i] = 0;
        if (skill) m_lv[ss][sl] = 1'b0;
        if (fd && m_busy) begin
            if (m_tv[p_set] && m_tag[p_set] == p_tag) m_lv[p_set][p_line] = 1'b1;
            else begin
                m_tag[p_set] = p_tag; m_tv[p_set] = 1; m_lv[p_set] = 8'b1 << p_line;
            end
            m_busy = 0;
        end
        if (efetch) begin m_busy = 1; p_tag = t; p_set = s; p_line = l; end
    endtask

    task automatic idle(input bit fd, input string req);
        step(0, 0, '0, 0, '0, 0, fd, req);
    endtask

    function automatic logic [31:0] rnd_addr();
        logic [16:0] tags [3] = '{17'h00000, 17'h00001, 17'h1abcd};
        logic [9:0]  sets [4] = '{10'd0, 10'd1, 10'd5, 10'd1023};
        return {tags[$urandom % 3], sets[$urandom % 4], 3'($urandom), 2'($urandom)};
    endfunction

    initial begin : watchdog
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] a, b, c;
        void'($urandom(32'd7));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        a = mk(17'h00123, 10'd3, 3'd2);
        b = mk(17'h00123, 10'd3, 3'd5);
        c = mk(17'h0abcd, 10'd3, 3'd2);
        // R10: empty after reset, read misses
        step(1, 0, a, 0, '0, 0, 0, "R10");
        // R3: access while pending gives nothing
        step(1, 0, b, 0, '0, 0, 0, "R3");
        idle(1, "R3");
        step(1, 0, a, 0, '0, 0, 0, "R2");
        // R4: second word under same tag keeps the first
        step(1, 0, b, 0, '0, 0, 0, "R4");
        idle(1, "R4");
        step(1, 0, a, 0, '0, 0, 0, "R4");
        step(1, 0, b, 0, '0, 0, 0, "R4");
        // R5: new tag takes over set, old words gone
        step(1, 0, c, 0, '0, 0, 0, "R5");
        idle(1, "R5");
        step(1, 0, c, 0, '0, 0, 0, "R5");
        step(1, 0, a, 0, '0, 0, 0, "R5");
        idle(1, "R5");
        // R6: write miss and write hit change nothing
        step(1, 1, mk(17'h00777, 10'd9, 3'd1), 0, '0, 0, 0, "R6");
        step(1, 1, a, 0, '0, 0, 0, "R6");
        step(1, 0, mk(17'h00777, 10'd9, 3'd1), 0, '0, 0, 0, "R6");
        idle(1, "R6");
        // R7: snoop to other tag ignored, matching snoop clears one word
        step(0, 0, '0, 1, c, 0, 0, "R7");
        step(1, 0, a, 0, '0, 0, 0, "R7");
        step(0, 0, '0, 1, a, 0, 0, "R7");
        step(1, 0, a, 0, '0, 0, 0, "R7");
        idle(1, "R7");
        // R9: same-cycle snoop beats the read
        step(1, 0, a, 1, a, 0, 0, "R9");
        idle(1, "R9");
        // R11: stray fill ignored
        idle(1, "R11");
        step(1, 0, a, 0, '0, 0, 0, "R11");
        // R8: flush empties everything; flush with read in same cycle
        step(1, 0, a, 0, '0, 1, 0, "R8");
        idle(1, "R8");
        step(0, 0, '0, 0, '0, 1, 0, "R8");
        step(1, 0, a, 0, '0, 0, 0, "R8");
        idle(1, "R8");
        // R9: fill completing with flush in the same cycle
        step(1, 0, b, 0, '0, 0, 0, "R9");
        step(0, 0, '0, 0, '0, 1, 1, "R9");
        step(1, 0, b, 0, '0, 0, 0, "R9");
        step(1, 0, a, 0, '0, 0, 0, "R9");
        idle(1, "R9");
        // Random mix
        for (int i = 0; i < 5000; i++) begin
            logic [31:0] ra, sa;
            bit av, aw, sv, fl, fd;
            ra = rnd_addr();
            sa = ($urandom % 3 == 0) ? ra : rnd_addr();
            av = ($urandom % 10) < 7;
            aw = ($urandom % 10) < 3;
            sv = ($urandom % 100) < 15;
            fl = ($urandom % 100) < 2;
            fd = m_busy ? (($urandom % 10) < 4) : (($urandom % 100) < 5);
            step(av, aw, ra, sv, sa, fl, fd, "R2");
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule